// File: doc/BRIEF.md
# Four-Mode Power State Controller

This block sequences a chip's clock and power controls across four operating modes: full-speed Normal, oscillator-clocked Slow, CPU-halted Idle and powered-down Sleep. Software selects a mode with a one-cycle write strobe carrying a two-bit code. The controller then steps the clock mux select, PLL enable, CPU clock enable and core power enable through a fixed order, so that the clock tree never switches onto a PLL that is off or still locking.

Slow mode is entered by moving the mux to the oscillator before the PLL is turned off. It is left by turning the PLL on, waiting a programmable lock count, and only then moving the mux back. Idle ends on any interrupt request. Sleep ends on the RTC alarm, or on any of the external wake lines that is enabled in a per-line mask. Those lines arrive asynchronously and pass through a synchroniser. On wake, core power returns first. The PLL is enabled after a programmable stabilisation count, and its lock count is then run before Normal mode resumes.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the block is in Normal: `clk_sel_osc`=0, `pll_en`=1, `cpu_clk_en`=1, `core_pwr_on`=1, `cur_mode`=0, `busy`=0. Mode codes are 0 Normal, 1 Slow, 2 Idle, 3 Sleep.
- R2: A write of code 1 in Normal sets `clk_sel_osc`=1 and `busy`=1 in the next cycle with `pll_en` still 1. One cycle later `pll_en` drops, `busy` clears, and `cur_mode` reads 1 from the first of these cycles.
- R3: A write of code 0 in Slow raises `pll_en` and `busy` in the next cycle. `clk_sel_osc` stays 1 for `lock_cnt`+1 cycles, then drops together with `busy`, and `cur_mode` returns to 0.
- R4: A write of code 2 in Normal clears `cpu_clk_en` in the next cycle, with `pll_en`=1, `core_pwr_on`=1, `clk_sel_osc`=0 and `cur_mode`=2.
- R5: In Idle, `irq_req` sampled high at a clock edge restores Normal at that edge, with `cpu_clk_en`=1.
- R6: A write of code 3 in Normal drives `core_pwr_on`=0, `pll_en`=0, `cpu_clk_en`=0, `clk_sel_osc`=1 and `cur_mode`=3 in the next cycle.
- R7: In Sleep, an enabled external wake line held high is seen at the third rising edge after it rises, which starts the wake sequence. An `rtc_alarm` high at an edge starts it at that edge.
- R8: A wake line whose `wake_mask` bit is 0 has no effect in Sleep.
- R9: The wake sequence holds `core_pwr_on`=1 with `pll_en`=0 for `stab_cnt`+1 cycles, then `pll_en`=1 for `lock_cnt`+1 cycles, with `busy`=1 and `cpu_clk_en`=0 throughout, and then enters Normal. Counts of zero give one cycle per step.
- R10: Mode writes while `busy`=1 are ignored.
- R11: In Slow, writes of any code other than 0 are ignored. Writes in Idle or Sleep are ignored, and so is `irq_req` outside Idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | One-cycle mode write strobe |
| mode_wdata | input | 2 | Requested mode code |
| lock_cnt | input | LOCK_W | PLL lock wait, in cycles minus one |
| stab_cnt | input | STAB_W | Power stabilisation wait, in cycles minus one |
| ext_wake | input | N_WAKE | Asynchronous external wake lines |
| wake_mask | input | N_WAKE | Per-line wake enable, 1 = enabled |
| rtc_alarm | input | 1 | Synchronous RTC alarm request |
| irq_req | input | 1 | Combined enabled interrupt request |
| clk_sel_osc | output | 1 | Clock mux select, 1 = oscillator |
| pll_en | output | 1 | PLL enable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| core_pwr_on | output | 1 | Core power domain enable |
| cur_mode | output | 2 | Mode currently held or being entered |
| busy | output | 1 | Transition sequence in progress |

## Verification
Every output is decoded from one state register, so a write, an interrupt or an RTC alarm sampled at a rising edge shows on the outputs right after that edge. An external wake line needs two synchroniser edges before the state edge that acts on it, so it shows after the third. Timed steps last their count plus one cycle. The bench's reference model advances at each rising edge from the same sampled inputs and builds these latencies in. Outputs are compared with the model at each falling edge, half a cycle after every change is due.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
   localparam logic [1:0] MODE_NORMAL = 2'd0;
   localparam logic [1:0] MODE_SLOW   = 2'd1;
   localparam logic [1:0] MODE_IDLE   = 2'd2;
   localparam logic [1:0] MODE_SLEEP  = 2'd3;

   typedef enum logic [2:0] {
      ST_RUN, ST_SLOW_SW, ST_SLOW, ST_SLOW_LOCK,
      ST_IDLE, ST_SLEEP, ST_WAKE_STAB, ST_WAKE_LOCK
   } pwr_state_e;

   typedef struct packed {
      logic clk_sel_osc;
      logic pll_en;
      logic cpu_clk_en;
      logic core_pwr_on;
   } pwr_ctl_t;
endpackage

// File: rtl/pwr_wake_sync.sv
module pwr_wake_sync #(
   parameter int N_WAKE   = 16,
   parameter int STAGES   = 2,
   parameter bit RTC_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_WAKE-1:0] ext_wake,
   input  logic [N_WAKE-1:0] wake_mask,
   input  logic              rtc_alarm,
   output logic              wake_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pwr_wake_sync: STAGES must be at least 2");
   end

   logic [N_WAKE-1:0] hit;
   logic              rtc_q;

   for (genvar i = 0; i < N_WAKE; i++) begin : g_line
      logic [STAGES-1:0] pipe;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe <= '0;
         else        pipe <= {pipe[STAGES-2:0], ext_wake[i]};
      end
      assign hit[i] = pipe[STAGES-1] & wake_mask[i];
   end

   if (RTC_REG) begin : g_rtc_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rtc_q <= 1'b0;
         else        rtc_q <= rtc_alarm;
      end
   end else begin : g_rtc_direct
      assign rtc_q = rtc_alarm;
   end

   assign wake_o = (|hit) | rtc_q;

   // R8
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_mask == '0 && !rtc_q) |-> !wake_o);
endmodule

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);
   if (W < 1) begin : g_bad_w
      $error("pwr_seq_timer: W must be positive");
   end

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pwr_mode_pkg::*;
#(
   parameter int N_WAKE  = 16,
   parameter int LOCK_W  = 12,
   parameter int STAB_W  = 12,
   parameter int SYNC_N  = 2,
   parameter bit RTC_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr,
   input  logic [1:0]        mode_wdata,
   input  logic [LOCK_W-1:0] lock_cnt,
   input  logic [STAB_W-1:0] stab_cnt,
   input  logic [N_WAKE-1:0] ext_wake,
   input  logic [N_WAKE-1:0] wake_mask,
   input  logic              rtc_alarm,
   input  logic              irq_req,
   output logic              clk_sel_osc,
   output logic              pll_en,
   output logic              cpu_clk_en,
   output logic              core_pwr_on,
   output logic [1:0]        cur_mode,
   output logic              busy
);
   localparam int TW = (LOCK_W > STAB_W) ? LOCK_W : STAB_W;

   if (N_WAKE < 1 || N_WAKE > 32) begin : g_bad_nwake
      $error("pwr_mode_ctrl: N_WAKE must be 1..32");
   end

   pwr_state_e    st, st_n;
   logic          wake, t_load, t_zero;
   logic [TW-1:0] t_val;
   pwr_ctl_t      ctl;

   pwr_wake_sync #(.N_WAKE(N_WAKE), .STAGES(SYNC_N), .RTC_REG(RTC_REG)) u_wake (
      .clk(clk), .rst_n(rst_n), .ext_wake(ext_wake), .wake_mask(wake_mask),
      .rtc_alarm(rtc_alarm), .wake_o(wake)
   );

   pwr_seq_timer #(.W(TW)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .zero(t_zero)
   );

   always_comb begin
      st_n   = st;
      t_load = 1'b0;
      t_val  = '0;
      unique case (st)
         ST_RUN: begin
            if (mode_wr) begin
               if (mode_wdata == MODE_SLOW)       st_n = ST_SLOW_SW;
               else if (mode_wdata == MODE_IDLE)  st_n = ST_IDLE;
               else if (mode_wdata == MODE_SLEEP) st_n = ST_SLEEP;
            end
         end
         ST_SLOW_SW: st_n = ST_SLOW;
         ST_SLOW: begin
            if (mode_wr && mode_wdata == MODE_NORMAL) begin
               st_n   = ST_SLOW_LOCK;
               t_load = 1'b1;
               t_val  = TW'(lock_cnt);
            end
         end
         ST_SLOW_LOCK: if (t_zero) st_n = ST_RUN;
         ST_IDLE:      if (irq_req) st_n = ST_RUN;
         ST_SLEEP: begin
            if (wake) begin
               st_n   = ST_WAKE_STAB;
               t_load = 1'b1;
               t_val  = TW'(stab_cnt);
            end
         end
         ST_WAKE_STAB: begin
            if (t_zero) begin
               st_n   = ST_WAKE_LOCK;
               t_load = 1'b1;
               t_val  = TW'(lock_cnt);
            end
         end
         ST_WAKE_LOCK: if (t_zero) st_n = ST_RUN;
         default:      st_n = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_RUN;
      else        st <= st_n;
   end

   always_comb begin
      unique case (st)
         ST_RUN:       ctl = '{1'b0, 1'b1, 1'b1, 1'b1};
         ST_SLOW_SW:   ctl = '{1'b1, 1'b1, 1'b1, 1'b1};
         ST_SLOW:      ctl = '{1'b1, 1'b0, 1'b1, 1'b1};
         ST_SLOW_LOCK: ctl = '{1'b1, 1'b1, 1'b1, 1'b1};
         ST_IDLE:      ctl = '{1'b0, 1'b1, 1'b0, 1'b1};
         ST_SLEEP:     ctl = '{1'b1, 1'b0, 1'b0, 1'b0};
         ST_WAKE_STAB: ctl = '{1'b1, 1'b0, 1'b0, 1'b1};
         default:      ctl = '{1'b1, 1'b1, 1'b0, 1'b1};
      endcase
   end

   assign clk_sel_osc = ctl.clk_sel_osc;
   assign pll_en      = ctl.pll_en;
   assign cpu_clk_en  = ctl.cpu_clk_en;
   assign core_pwr_on = ctl.core_pwr_on;

   always_comb begin
      unique case (st)
         ST_RUN:                              cur_mode = MODE_NORMAL;
         ST_SLOW_SW, ST_SLOW, ST_SLOW_LOCK:   cur_mode = MODE_SLOW;
         ST_IDLE:                             cur_mode = MODE_IDLE;
         default:                             cur_mode = MODE_SLEEP;
      endcase
   end

   assign busy = (st == ST_SLOW_SW) || (st == ST_SLOW_LOCK) ||
                 (st == ST_WAKE_STAB) || (st == ST_WAKE_LOCK);

   // R2
   pll_off_after_mux_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(pll_en) && core_pwr_on) |-> $past(clk_sel_osc));
   // R3
   mux_back_on_live_pll_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_sel_osc) |-> (pll_en && $past(pll_en)));
   // R6
   sleep_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !core_pwr_on |-> (!pll_en && !cpu_clk_en));
   // R5
   idle_irq_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && irq_req) |=> cpu_clk_en);
   // R10
   busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && mode_wr && cur_mode == MODE_SLEEP) |=> cur_mode != MODE_SLOW);
endmodule

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;
   localparam int CLK_PER = 10;
   localparam int NW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode_wr = 1'b0;
   logic [1:0] mode_wdata = 2'd0;
   logic [11:0] lock_cnt = 12'd5;
   logic [11:0] stab_cnt = 12'd3;
   logic [NW-1:0] ext_wake = '0;
   logic [NW-1:0] wake_mask = 16'h00F0;
   logic rtc_alarm = 1'b0;
   logic irq_req = 1'b0;
   logic clk_sel_osc, pll_en, cpu_clk_en, core_pwr_on, busy;
   logic [1:0] cur_mode;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   bit checking = 1'b0;
   bit done = 1'b0;
   string req = "R1";

   always #(CLK_PER/2) clk = ~clk;

   pwr_mode_ctrl dut (
      .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
      .lock_cnt(lock_cnt), .stab_cnt(stab_cnt), .ext_wake(ext_wake),
      .wake_mask(wake_mask), .rtc_alarm(rtc_alarm), .irq_req(irq_req),
      .clk_sel_osc(clk_sel_osc), .pll_en(pll_en), .cpu_clk_en(cpu_clk_en),
      .core_pwr_on(core_pwr_on), .cur_mode(cur_mode), .busy(busy)
   );

   // Reference model: phase number plus a countdown and a wake-line history.
   int ph = 0;
   int left = 0;
   logic [NW-1:0] seen1 = '0, seen2 = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         ph <= 0; left <= 0; seen1 <= '0; seen2 <= '0;
      end else begin
         seen1 <= ext_wake;
         seen2 <= seen1;
         case (ph)
            0: if (mode_wr) begin
                  if (mode_wdata == 2'd1) ph <= 1;
                  else if (mode_wdata == 2'd2) ph <= 4;
                  else if (mode_wdata == 2'd3) ph <= 5;
               end
            1: ph <= 2;
            2: if (mode_wr && mode_wdata == 2'd0) begin ph <= 3; left <= int'(lock_cnt); end
            3: if (left == 0) ph <= 0; else left <= left - 1;
            4: if (irq_req) ph <= 0;
            5: if (((seen2 & wake_mask) != '0) || rtc_alarm) begin ph <= 6; left <= int'(stab_cnt); end
            6: if (left == 0) begin ph <= 7; left <= int'(lock_cnt); end else left <= left - 1;
            default: if (left == 0) ph <= 0; else left <= left - 1;
         endcase
      end
   end

   // {osc, pll, cpu, core, mode[1:0], busy}
   function automatic logic [6:0] expect_of(int p);
      case (p)
         0: return 7'b0111_00_0;
         1: return 7'b1111_01_1;
         2: return 7'b1011_01_0;
         3: return 7'b1111_01_1;
         4: return 7'b0101_10_0;
         5: return 7'b1000_11_0;
         6: return 7'b1001_11_1;
         default: return 7'b1101_11_1;
      endcase
   endfunction

   task automatic check_now(string tag);
      logic [6:0] got, exp;
      got = {clk_sel_osc, pll_en, cpu_clk_en, core_pwr_on, cur_mode, busy};
      exp = expect_of(ph);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, got, exp);
      end
   endtask

   always @(negedge clk) if (checking && !done) check_now(req);

   task automatic wait_cyc(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic write_mode(logic [1:0] m);
      @(negedge clk);
      mode_wr = 1'b1; mode_wdata = m;
      @(negedge clk);
      mode_wr = 1'b0;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      // R1: outputs during and after reset
      wait_cyc(2);
      check_now("R1");
      rst_n = 1'b1;
      checking = 1'b1;
      req = "R1"; wait_cyc(3);
      // R2: enter Slow
      req = "R2"; write_mode(2'd1); wait_cyc(4);
      // R11: ignored writes and irq in Slow
      req = "R11"; write_mode(2'd2); write_mode(2'd3);
      irq_req = 1'b1; wait_cyc(2); irq_req = 1'b0; wait_cyc(2);
      // R3 and R10: leave Slow, write during lock wait
      req = "R3"; write_mode(2'd0);
      req = "R10"; write_mode(2'd3); write_mode(2'd1);
      req = "R3"; wait_cyc(8);
      // R4, R5: Idle and its exit
      req = "R4"; write_mode(2'd2); wait_cyc(3);
      req = "R11"; write_mode(2'd3); wait_cyc(2);
      req = "R5"; irq_req = 1'b1; wait_cyc(1); irq_req = 1'b0; wait_cyc(3);
      // R6, R8, R7, R9: Sleep, masked line, enabled line, wake sequence
      req = "R6"; write_mode(2'd3); wait_cyc(3);
      req = "R8"; ext_wake[2] = 1'b1; wait_cyc(6); ext_wake[2] = 1'b0; wait_cyc(3);
      req = "R7"; ext_wake[5] = 1'b1; wait_cyc(4); ext_wake[5] = 1'b0;
      req = "R9"; wait_cyc(14);
      // R7, R9: RTC wake with zero counts
      lock_cnt = 12'd0; stab_cnt = 12'd0;
      req = "R6"; write_mode(2'd3); wait_cyc(2);
      req = "R7"; rtc_alarm = 1'b1; wait_cyc(1); rtc_alarm = 1'b0;
      req = "R9"; wait_cyc(5);
      // R3 with zero lock count
      req = "R3"; write_mode(2'd1); wait_cyc(3); write_mode(2'd0); wait_cyc(4);
      // R1: Normal write in Normal keeps state
      req = "R1"; write_mode(2'd0); wait_cyc(3);
      finish_run();
   end
endmodule